// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Splitter

This block is the fetch-stage field splitter of a single-cycle processor whose instructions are encoded as a stream of bytes. Each cycle the instruction memory presents six consecutive bytes, starting at the current program counter, together with an error flag. The block is purely combinational. It cuts the leading byte into an opcode and a function selector, and classifies the opcode. It pulls the optional register byte and the optional 32-bit little-endian constant out of the bytes that follow. It then computes the address of the next sequential instruction from the length the opcode implies.

The encoded length of an instruction is 1, 2, 5 or 6 bytes, depending on whether the opcode carries a register byte, a constant, or both. The outputs feed the decode and PC-update logic directly. There is no handshake: the fetch window is a plain combinational path, so it has no back-pressure and nothing to stall, and its outputs follow its inputs within the same cycle.

Top module: `fetch_splitter`

## Requirements
- R1: The upper nibble of byte 0 (bits 7:4 of `fetch_bytes_i`) is output as `icode_o`, and the lower nibble (bits 3:0) is output as `ifun_o`.
- R2: `instr_valid_o` is 1 for opcodes 0x0 to 0xB and 0 for opcodes 0xC to 0xF. The opcodes are 0 halt, 1 nop, 2 reg-move, 3 imm-move, 4 store, 5 load, 6 alu-op, 7 jump, 8 call, 9 return, A push and B pop.
- R3: `need_regs_o` is 1 exactly for opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB.
- R4: `need_const_o` is 1 exactly for opcodes 0x3, 0x4, 0x5, 0x7 and 0x8.
- R5: When `need_regs_o` is 1, `reg_a_o` is the upper nibble of byte 1 and `reg_b_o` is its lower nibble. Otherwise both outputs are 0xF.
- R6: When `need_const_o` is 1, `const_o` is the little-endian word in bytes 2 to 5 if `need_regs_o` is 1, and in bytes 1 to 4 otherwise. When `need_const_o` is 0, `const_o` is 0. Byte k sits at bits 8k+7:8k.
- R7: `next_pc_o` equals `pc_i + 1 + need_regs_o + 4*need_const_o`, modulo 2^32.
- R8: When `imem_err_i` is 1, the opcode is taken as nop (`icode_o`=1, `ifun_o`=0). In that case `instr_valid_o`=1, both need flags are 0, both register outputs are 0xF, `const_o`=0 and `next_pc_o`=`pc_i`+1, whatever the fetched bytes hold.
- R9: An invalid opcode (0xC to 0xF) has both need flags at 0. Its `next_pc_o` is `pc_i`+1, and its register and constant outputs take their empty values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of byte 0 of the fetch window |
| fetch_bytes_i | input | 48 | Six fetched bytes; byte k at bits 8k+7:8k |
| imem_err_i | input | 1 | Instruction memory reported an access error |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function selector nibble |
| reg_a_o | output | 4 | First register specifier, 0xF if none |
| reg_b_o | output | 4 | Second register specifier, 0xF if none |
| const_o | output | 32 | Embedded constant, 0 if none |
| next_pc_o | output | 32 | Address of the following instruction |
| instr_valid_o | output | 1 | Opcode is recognised |
| need_regs_o | output | 1 | A register byte follows the opcode byte |
| need_const_o | output | 1 | A 32-bit constant is present |

## Verification
The in-line checks assume only that the inputs carry defined 0/1 values. They skip any evaluation in which a port is still unknown, so the settling of the path at time zero is not flagged. The stimulus always drives every input bit. It sweeps all 256 values of the opcode byte, with the error flag both clear and set. Byte patterns and PC values, including one near the top of the address space where the addition wraps, are fixed and fully defined. All outputs are sampled half a clock after the inputs change.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned WORD_W      = 8 * WORD_BYTES;
  localparam int unsigned WIN_BYTES   = 2 + WORD_BYTES;
  localparam int unsigned WIN_W       = 8 * WIN_BYTES;
  localparam int unsigned NIB_W       = 4;

  typedef enum logic [NIB_W-1:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMV  = 4'h2,
    OP_IRMV  = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  localparam logic [NIB_W-1:0] NO_REG = 4'hF;

  typedef struct packed {
    logic valid;
    logic regs;
    logic cnst;
  } op_class_t;
endpackage

// File: rtl/fetch_opclass.sv
module fetch_opclass
  import fetch_pkg::*;
(
  input  logic [7:0]       op_byte_i,
  input  logic             err_i,
  output logic [NIB_W-1:0] icode_o,
  output logic [NIB_W-1:0] ifun_o,
  output op_class_t        cls_o
);
  logic [NIB_W-1:0] code;

  always_comb begin
    if (err_i) begin
      code    = OP_NOP;
      ifun_o  = '0;
    end else begin
      code    = op_byte_i[7:4];
      ifun_o  = op_byte_i[3:0];
    end
    icode_o = code;
  end

  always_comb begin
    cls_o = '{valid: 1'b1, regs: 1'b0, cnst: 1'b0};
    unique case (code)
      OP_HALT, OP_NOP, OP_RET:      cls_o = '{1'b1, 1'b0, 1'b0};
      OP_RRMV, OP_ALU,
      OP_PUSH, OP_POP:              cls_o = '{1'b1, 1'b1, 1'b0};
      OP_IRMV, OP_STORE, OP_LOAD:   cls_o = '{1'b1, 1'b1, 1'b1};
      OP_JUMP, OP_CALL:             cls_o = '{1'b1, 1'b0, 1'b1};
      default:                      cls_o = '{1'b0, 1'b0, 1'b0};
    endcase
  end

  always_comb begin
    if (!$isunknown({op_byte_i, err_i})) begin
      p_err_nop_r8: assert (!err_i || (icode_o == 4'h1 && ifun_o == 4'h0 && cls_o.valid))
        else $error("error flag did not force nop");
      p_const_needs_valid_r4: assert (!cls_o.cnst || cls_o.valid)
        else $error("constant flagged on invalid opcode");
      p_invalid_empty_r9: assert (cls_o.valid || (!cls_o.regs && !cls_o.cnst))
        else $error("invalid opcode carries fields");
      p_valid_range_r2: assert (cls_o.valid == (icode_o <= 4'hB))
        else $error("validity disagrees with opcode range");
    end
  end
endmodule

// File: rtl/fetch_fields.sv
module fetch_fields
  import fetch_pkg::*;
(
  input  logic [WIN_W-1:0]  win_i,
  input  op_class_t         cls_i,
  output logic [NIB_W-1:0]  reg_a_o,
  output logic [NIB_W-1:0]  reg_b_o,
  output logic [WORD_W-1:0] const_o
);
  logic [7:0] byte_q [WIN_BYTES];
  logic [WORD_W-1:0] word_lo, word_hi;

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_bytes
    assign byte_q[k] = win_i[8*k +: 8];
  end

  for (genvar n = 0; n < WORD_BYTES; n++) begin : g_word
    assign word_lo[8*n +: 8] = byte_q[1+n];
    assign word_hi[8*n +: 8] = byte_q[2+n];
  end

  always_comb begin
    reg_a_o = cls_i.regs ? byte_q[1][7:4] : NO_REG;
    reg_b_o = cls_i.regs ? byte_q[1][3:0] : NO_REG;
    if (!cls_i.cnst)     const_o = '0;
    else if (cls_i.regs) const_o = word_hi;
    else                 const_o = word_lo;
  end

  always_comb begin
    if (!$isunknown({win_i, cls_i})) begin
      p_noreg_empty_r5: assert (cls_i.regs || (reg_a_o == NO_REG && reg_b_o == NO_REG))
        else $error("register outputs not empty");
      p_noconst_zero_r6: assert (cls_i.cnst || const_o == '0)
        else $error("constant not zero");
    end
  end
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
  import fetch_pkg::*;
(
  input  logic [ADDR_W-1:0] pc_i,
  input  op_class_t         cls_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  logic [2:0] len;

  always_comb begin
    len = 3'd1;
    if (cls_i.regs) len = len + 3'd1;
    if (cls_i.cnst) len = len + 3'(WORD_BYTES);
    next_pc_o = pc_i + ADDR_W'(len);
  end

  logic [ADDR_W-1:0] step;
  always_comb begin
    step = next_pc_o - pc_i;
    if (!$isunknown({pc_i, cls_i})) begin
      p_len_set_r7: assert (step == 1 || step == 2 || step == 5 || step == 6)
        else $error("illegal instruction length %0d", step);
      p_len_one_r9: assert (cls_i.regs || cls_i.cnst || step == 1)
        else $error("bare opcode length not 1");
    end
  end
endmodule

// File: rtl/fetch_splitter.sv
module fetch_splitter
  import fetch_pkg::*;
(
  input  logic [31:0] pc_i,
  input  logic [47:0] fetch_bytes_i,
  input  logic        imem_err_i,
  output logic [3:0]  icode_o,
  output logic [3:0]  ifun_o,
  output logic [3:0]  reg_a_o,
  output logic [3:0]  reg_b_o,
  output logic [31:0] const_o,
  output logic [31:0] next_pc_o,
  output logic        instr_valid_o,
  output logic        need_regs_o,
  output logic        need_const_o
);
  op_class_t cls;

  fetch_opclass u_cls (
    .op_byte_i (fetch_bytes_i[7:0]),
    .err_i     (imem_err_i),
    .icode_o   (icode_o),
    .ifun_o    (ifun_o),
    .cls_o     (cls)
  );

  fetch_fields u_fld (
    .win_i   (fetch_bytes_i),
    .cls_i   (cls),
    .reg_a_o (reg_a_o),
    .reg_b_o (reg_b_o),
    .const_o (const_o)
  );

  fetch_next_pc u_npc (
    .pc_i      (pc_i),
    .cls_i     (cls),
    .next_pc_o (next_pc_o)
  );

  assign instr_valid_o = cls.valid;
  assign need_regs_o   = cls.regs;
  assign need_const_o  = cls.cnst;
endmodule

// File: tb/fetch_splitter_test.sv
module fetch_splitter_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc;
  logic [47:0] win;
  logic        err;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] cval, npc;
  logic        vld, nreg, ncst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fetch_splitter uut (
    .pc_i(pc), .fetch_bytes_i(win), .imem_err_i(err),
    .icode_o(icode), .ifun_o(ifun), .reg_a_o(ra), .reg_b_o(rb),
    .const_o(cval), .next_pc_o(npc), .instr_valid_o(vld),
    .need_regs_o(nreg), .need_const_o(ncst)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pc=%h win=%h err=%b: got %h expected %h", req, pc, win, err, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] p, logic [47:0] w, logic e);
    logic [3:0] ec, ef, ea, eb;
    logic ev, er, ek;
    logic [31:0] ek_val;
    @(negedge clk);
    pc = p; win = w; err = e;
    @(posedge clk); #1;
    ec = e ? 4'h1 : w[7:4];
    ef = e ? 4'h0 : w[3:0];
    ev = (ec < 4'd12);
    er = (ec == 2 || ec == 3 || ec == 4 || ec == 5 || ec == 6 || ec == 10 || ec == 11);
    ek = (ec == 3 || ec == 4 || ec == 5 || ec == 7 || ec == 8);
    ea = er ? w[15:12] : 4'hF;
    eb = er ? w[11:8]  : 4'hF;
    ek_val = 0;
    if (ek) ek_val = er ? w[47:16] : w[39:8];
    chk(e ? "R8 icode" : "R1 icode", 32'(icode), 32'(ec));
    chk(e ? "R8 ifun"  : "R1 ifun",  32'(ifun),  32'(ef));
    chk("R2 valid", 32'(vld), 32'(ev));
    chk("R3 need_regs", 32'(nreg), 32'(er));
    chk("R4 need_const", 32'(ncst), 32'(ek));
    chk("R5 reg_a", 32'(ra), 32'(ea));
    chk("R5 reg_b", 32'(rb), 32'(eb));
    chk("R6 const", cval, ek_val);
    chk(ev ? "R7 next_pc" : "R9 next_pc", npc, p + 32'd1 + 32'(er) + 32'(4 * ek));
  endtask

  initial begin
    pc = 0; win = 0; err = 0;
    apply(32'h0, 48'h0, 1'b0);   // all-zero window: halt, length 1
    for (int e = 0; e < 2; e++)
      for (int pi = 0; pi < 3; pi++)
        for (int op = 0; op < 256; op++)
          for (int s = 0; s < 2; s++) begin
            logic [31:0] p;
            logic [47:0] w;
            p = (pi == 0) ? 32'h0000_1000 : (pi == 1) ? 32'hFFFF_FFFC : 32'h8765_4321;
            for (int k = 1; k < 6; k++)
              w[8*k +: 8] = 8'(k * 8'h23 + s * 8'h5B + op);
            w[7:0] = 8'(op);
            apply(p, w, e[0]);
          end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule